// File: doc/BRIEF.md
# BCD Real-Time Calendar Clock

This block keeps the time of day and a calendar date, all held as binary-coded decimal digits. A reference tick input is divided down to a one-millisecond step. Each step advances a digit chain that runs from milliseconds through seconds, minutes, hours (24-hour form), day of month, month and a four-digit year. The day limit follows the month length, and February gets 29 days in leap years.

Software sets the time, the date, an alarm and a control word through a single write port. The current time and date are always visible on two read-out buses. An alarm interrupt fires when the clock steps into a second whose day of month, hour, minute and second equal the programmed alarm, so an alarm can lie up to one month ahead. A separate periodic interrupt, taken from a free-running binary prescaler on the reference tick, runs at a power-of-two rate from 1 Hz to 512 Hz.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: The millisecond count advances by one on every REF_PER_MS-th reference tick. The new value is visible in the cycle after the clock edge that took the completing tick. Cycles without a tick do not count.
- R2: Every field is BCD. The millisecond field (time_o[11:0]) goes from 999 to 000 and carries into seconds (time_o[19:12]). Seconds go from 59 to 00 and carry into minutes (time_o[27:20]). Minutes go from 59 to 00 and carry into hours.
- R3: Hours (time_o[35:28]) use 24-hour form and go from 23 to 00, carrying into the day of month.
- R4: The day of month (date_o[7:0]) goes back to 01 after the last day of its month. Months 04, 06, 09 and 11 have 30 days, and February has 28 days, or 29 in a leap year. A year is a leap year when it divides by 4, unless it divides by 100 and not by 400. Month (date_o[15:8]) goes from 12 to 01 and carries into the year (date_o[31:16]), and year 9999 goes to 0000.
- R5: A write to address 0 loads hours from wr_data[23:16], minutes from [15:8] and seconds from [7:0]. It clears the millisecond field and the tick divider.
- R6: A write to address 1 loads the year from wr_data[31:16], the month from [15:8] and the day from [7:0]. A write to address 0 or 1 cancels any millisecond advance in that cycle.
- R7: A write to address 2 sets the alarm: day in wr_data[31:24], hour in [23:16], minute in [15:8] and second in [7:0]. alarm_irq is high for one cycle, in the same cycle as the new time, when the millisecond field wraps to 000 and the new day, hour, minute and second all equal the alarm. An alarm day of 00 never matches.
- R8: A write to address 3 sets the control word: wr_data[3:0] is the rate selector s, wr_data[4] enables the periodic interrupt, and wr_data[5] enables the alarm. While enabled, tick_irq pulses for one cycle once every 2^(REF_LOG2-s) reference ticks. Selector values above 9 act as 9. The pulse is aligned to a free-running prescaler and follows the edge of the tick that completes the period.
- R9: After reset the time is 00:00:00.000, the date is 2000-01-01, the alarm and control word are zero, and both interrupts are low.
- R10: While the alarm enable bit is 0, alarm_irq stays low, even when the time steps into a matching second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick, one pulse per reference period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 time, 1 date, 2 alarm, 3 control |
| wr_data | input | 32 | Write data |
| time_o | output | 36 | Hours, minutes, seconds, milliseconds in BCD |
| date_o | output | 32 | Year, month, day of month in BCD |
| alarm_irq | output | 1 | Alarm match pulse |
| tick_irq | output | 1 | Periodic interrupt pulse |

## Verification
Every result is due one cycle after the clock edge that takes its cause:
- a millisecond step, a carry through any number of digits and a register load all appear after that edge;
- alarm_irq rises in the same cycle as the new second;
- tick_irq follows the edge of the tick that completes its period, gated by the control word held before that edge.

A behavioural model in the bench updates at each rising edge under these rules, using plain integers for the time and date. The design's outputs are compared with the model at every falling edge, half a cycle after the edge that produced them. Rollover, leap-year, alarm and rate scenarios are added as explicit checks at settled points.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        REG_TIME  = 2'd0,
        REG_DATE  = 2'd1,
        REG_ALARM = 2'd2,
        REG_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [7:0]  hour;
        logic [7:0]  min;
        logic [7:0]  sec;
        logic [11:0] ms;
    } tod_t;

    typedef struct packed {
        logic [15:0] year;
        logic [7:0]  month;
        logic [7:0]  day;
    } cal_t;

    typedef struct packed {
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } alarm_t;

    typedef struct packed {
        logic       alarm_en;
        logic       tick_en;
        logic [3:0] rate;
    } ctrl_t;

    localparam int DIGITS_MAX = 4;

    // Add one to a four-digit BCD value; 9999 wraps to 0000.
    function automatic logic [15:0] bcd_inc(input logic [15:0] v);
        logic [15:0] r;
        logic        c;
        r = v;
        c = 1'b1;
        for (int i = 0; i < DIGITS_MAX; i++) begin
            if (c) begin
                if (r[i*4 +: 4] == 4'd9) begin
                    r[i*4 +: 4] = 4'd0;
                end else begin
                    r[i*4 +: 4] = r[i*4 +: 4] + 4'd1;
                    c = 1'b0;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        logic [15:0] w;
        w = bcd_inc({8'h00, v});
        return w[7:0];
    endfunction

    function automatic logic [11:0] bcd_inc12(input logic [11:0] v);
        logic [15:0] w;
        w = bcd_inc({4'h0, v});
        return w[11:0];
    endfunction

    // Two BCD digits divisible by four: even tens need units 0/4/8, odd tens 2/6.
    function automatic logic bcd_div4(input logic [7:0] b);
        if (b[4] == 1'b0)
            return (b[3:0] == 4'd0) || (b[3:0] == 4'd4) || (b[3:0] == 4'd8);
        return (b[3:0] == 4'd2) || (b[3:0] == 4'd6);
    endfunction

    function automatic logic is_leap(input logic [15:0] y);
        if (y[7:0] == 8'h00)
            return bcd_div4(y[15:8]);
        return bcd_div4(y[7:0]);
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] m, input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_ms_div.sv
module rtc_ms_div #(
    parameter int REF_PER_MS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic ref_tick,
    output logic ms_step
);
    localparam int CW = (REF_PER_MS > 1) ? $clog2(REF_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(REF_PER_MS - 1);

    logic [CW-1:0] cnt_q;

    assign ms_step = ref_tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (ref_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assert_div_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic        wr_time,
    input  logic        wr_date,
    input  logic [23:0] time_wd,
    input  logic [31:0] date_wd,
    output tod_t        tod_o,
    output cal_t        cal_o,
    output logic        sec_evt_o
);
    tod_t       tod_q;
    cal_t       cal_q;
    logic       sec_evt_q;
    logic [7:0] last_day;
    logic       advance;

    assign last_day = month_days(cal_q.month, is_leap(cal_q.year));
    assign advance  = step && !wr_time && !wr_date;

    always_ff @(posedge clk) begin
        if (rst) begin
            tod_q     <= '0;
            cal_q     <= '{year: 16'h2000, month: 8'h01, day: 8'h01};
            sec_evt_q <= 1'b0;
        end else begin
            sec_evt_q <= 1'b0;
            if (wr_time) begin
                tod_q.hour <= time_wd[23:16];
                tod_q.min  <= time_wd[15:8];
                tod_q.sec  <= time_wd[7:0];
                tod_q.ms   <= '0;
            end
            if (wr_date) begin
                cal_q.year  <= date_wd[31:16];
                cal_q.month <= date_wd[15:8];
                cal_q.day   <= date_wd[7:0];
            end
            if (advance) begin
                if (tod_q.ms != 12'h999) begin
                    tod_q.ms <= bcd_inc12(tod_q.ms);
                end else begin
                    tod_q.ms  <= '0;
                    sec_evt_q <= 1'b1;
                    if (tod_q.sec != 8'h59) begin
                        tod_q.sec <= bcd_inc8(tod_q.sec);
                    end else begin
                        tod_q.sec <= 8'h00;
                        if (tod_q.min != 8'h59) begin
                            tod_q.min <= bcd_inc8(tod_q.min);
                        end else begin
                            tod_q.min <= 8'h00;
                            if (tod_q.hour != 8'h23) begin
                                tod_q.hour <= bcd_inc8(tod_q.hour);
                            end else begin
                                tod_q.hour <= 8'h00;
                                if (cal_q.day != last_day) begin
                                    cal_q.day <= bcd_inc8(cal_q.day);
                                end else begin
                                    cal_q.day <= 8'h01;
                                    if (cal_q.month != 8'h12) begin
                                        cal_q.month <= bcd_inc8(cal_q.month);
                                    end else begin
                                        cal_q.month <= 8'h01;
                                        cal_q.year  <= bcd_inc(cal_q.year);
                                    end
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    assign tod_o     = tod_q;
    assign cal_o     = cal_q;
    assign sec_evt_o = sec_evt_q;

    assert_ms_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (advance && tod_q.ms == 12'h999) |=> (tod_q.ms == 12'h000) && sec_evt_q);

    assert_ms_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!step && !wr_time) |=> $stable(tod_q.ms));

    assert_hour_range_R3: assert property (@(posedge clk) disable iff (rst)
        tod_q.hour <= 8'h23);

    assert_day_range_R4: assert property (@(posedge clk) disable iff (rst)
        (cal_q.day != 8'h00) && (cal_q.day <= 8'h31));

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
    parameter int REF_LOG2 = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_tick,
    input  logic       en,
    input  logic [3:0] rate,
    output logic       pulse_o
);
    localparam int         PW       = REF_LOG2;
    localparam logic [3:0] RATE_MAX = 4'd9;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] mask;
    logic [3:0]    rate_c;
    logic          pulse_q;

    assign rate_c = (rate > RATE_MAX) ? RATE_MAX : rate;
    assign mask   = {PW{1'b1}} >> rate_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= en && ref_tick && ((pre_q & mask) == mask);
            if (ref_tick) pre_q <= pre_q + 1'b1;
        end
    end

    assign pulse_o = pulse_q;

    assert_tick_gap_R8: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    assert_tick_gated_R8: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(en));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  alarm_t alm,
    input  alarm_t now,
    input  logic   sec_evt,
    input  logic   en,
    output logic   hit
);
    assign hit = en && sec_evt && (alm.day != 8'h00) && (alm == now);
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_pkg::*;
#(
    parameter int REF_PER_MS = 4,
    parameter int REF_LOG2   = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_tick,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic [35:0] time_o,
    output logic [31:0] date_o,
    output logic        alarm_irq,
    output logic        tick_irq
);
    logic   wr_time, wr_date, ms_step, sec_evt;
    tod_t   tod;
    cal_t   cal;
    alarm_t alarm_q, now;
    ctrl_t  ctrl_q;

    assign wr_time = wr_en && (wr_addr == REG_TIME);
    assign wr_date = wr_en && (wr_addr == REG_DATE);

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_ALARM) alarm_q <= alarm_t'(wr_data);
            if (wr_addr == REG_CTRL)  ctrl_q  <= ctrl_t'(wr_data[5:0]);
        end
    end

    rtc_ms_div #(.REF_PER_MS(REF_PER_MS)) u_div (
        .clk(clk), .rst(rst), .clear(wr_time), .ref_tick(ref_tick), .ms_step(ms_step)
    );

    rtc_time_chain u_chain (
        .clk(clk), .rst(rst), .step(ms_step), .wr_time(wr_time), .wr_date(wr_date),
        .time_wd(wr_data[23:0]), .date_wd(wr_data), .tod_o(tod), .cal_o(cal),
        .sec_evt_o(sec_evt)
    );

    assign now = '{day: cal.day, hour: tod.hour, min: tod.min, sec: tod.sec};

    rtc_alarm u_alarm (
        .alm(alarm_q), .now(now), .sec_evt(sec_evt), .en(ctrl_q.alarm_en), .hit(alarm_irq)
    );

    rtc_periodic #(.REF_LOG2(REF_LOG2)) u_per (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .en(ctrl_q.tick_en),
        .rate(ctrl_q.rate), .pulse_o(tick_irq)
    );

    assign time_o = tod;
    assign date_o = cal;

    assert_time_write_R5: assert property (@(posedge clk) disable iff (rst)
        wr_time |=> (tod.ms == 12'h000));

    assert_alarm_on_second_R7: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> (tod.ms == 12'h000));

    assert_alarm_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.alarm_en |-> !alarm_irq);

endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb_top;
    localparam int N_MS  = 4;
    localparam int L2    = 12;
    localparam int WDOG  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [35:0] time_o;
    logic [31:0] date_o;
    logic        alarm_irq, tick_irq;

    int n_checks = 0;
    int n_err    = 0;
    int cycles   = 0;
    int ref_mode = 0;
    int alm_cnt  = 0;
    int per_cnt  = 0;
    int m_per_cnt = 0;

    // reference model state
    int m_ms, m_sec, m_min, m_hour, m_day, m_mon, m_year, m_div, m_pre;
    int a_day, a_hour, a_min, a_sec;
    int c_rate;
    bit c_aen, c_pen, m_evt, m_per, m_alarm;

    rtc_bcd_calendar #(.REF_PER_MS(N_MS), .REF_LOG2(L2)) dut_i (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .time_o(time_o), .date_o(date_o),
        .alarm_irq(alarm_irq), .tick_irq(tick_irq)
    );

    always #2 clk = ~clk;

    function automatic int from_bcd(input logic [15:0] v);
        return v[15:12] * 1000 + v[11:8] * 100 + v[7:4] * 10 + v[3:0];
    endfunction

    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r;
        int x;
        x = v;
        for (int i = 0; i < 4; i++) begin
            r[i*4 +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    function automatic int days_in(input int mon, input int yr);
        bit lp;
        lp = ((yr % 4 == 0) && (yr % 100 != 0)) || (yr % 400 == 0);
        if (mon == 2) return lp ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [35:0] exp_time();
        logic [15:0] h, mi, s, ms;
        h = to_bcd(m_hour); mi = to_bcd(m_min); s = to_bcd(m_sec); ms = to_bcd(m_ms);
        return {h[7:0], mi[7:0], s[7:0], ms[11:0]};
    endfunction

    function automatic logic [31:0] exp_date();
        logic [15:0] y, mo, d;
        y = to_bcd(m_year); mo = to_bcd(m_mon); d = to_bcd(m_day);
        return {y, mo[7:0], d[7:0]};
    endfunction

    task automatic advance_ms();
        m_ms++;
        if (m_ms == 1000) begin
            m_ms = 0; m_evt = 1; m_sec++;
            if (m_sec == 60) begin
                m_sec = 0; m_min++;
                if (m_min == 60) begin
                    m_min = 0; m_hour++;
                    if (m_hour == 24) begin
                        m_hour = 0; m_day++;
                        if (m_day > days_in(m_mon, m_year)) begin
                            m_day = 1; m_mon++;
                            if (m_mon == 13) begin
                                m_mon = 1;
                                m_year = (m_year + 1) % 10000;
                            end
                        end
                    end
                end
            end
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_ms = 0; m_sec = 0; m_min = 0; m_hour = 0;
            m_day = 1; m_mon = 1; m_year = 2000;
            m_div = 0; m_pre = 0;
            a_day = 0; a_hour = 0; a_min = 0; a_sec = 0;
            c_rate = 0; c_aen = 0; c_pen = 0;
            m_evt = 0; m_per = 0; m_alarm = 0;
        end else begin
            bit wt, wd, stp;
            int re, plen;
            wt = wr_en && (wr_addr == 2'd0);
            wd = wr_en && (wr_addr == 2'd1);
            re = (c_rate > 9) ? 9 : c_rate;
            plen = 1 << (L2 - re);
            m_per = c_pen && ref_tick && ((m_pre % plen) == plen - 1);
            if (m_per) m_per_cnt++;
            if (ref_tick) m_pre = (m_pre + 1) % (1 << L2);
            stp = 0;
            if (wt) m_div = 0;
            else if (ref_tick) begin
                if (m_div == N_MS - 1) begin m_div = 0; stp = 1; end
                else m_div++;
            end
            m_evt = 0;
            if (wt) begin
                m_hour = from_bcd({8'h00, wr_data[23:16]});
                m_min  = from_bcd({8'h00, wr_data[15:8]});
                m_sec  = from_bcd({8'h00, wr_data[7:0]});
                m_ms   = 0;
            end
            if (wd) begin
                m_year = from_bcd(wr_data[31:16]);
                m_mon  = from_bcd({8'h00, wr_data[15:8]});
                m_day  = from_bcd({8'h00, wr_data[7:0]});
            end
            if (stp && !wt && !wd) advance_ms();
            if (wr_en && wr_addr == 2'd2) begin
                a_day  = from_bcd({8'h00, wr_data[31:24]});
                a_hour = from_bcd({8'h00, wr_data[23:16]});
                a_min  = from_bcd({8'h00, wr_data[15:8]});
                a_sec  = from_bcd({8'h00, wr_data[7:0]});
            end
            if (wr_en && wr_addr == 2'd3) begin
                c_rate = int'(wr_data[3:0]);
                c_pen  = wr_data[4];
                c_aen  = wr_data[5];
            end
            m_alarm = m_evt && c_aen && (a_day != 0) && (a_day == m_day) &&
                      (a_hour == m_hour) && (a_min == m_min) && (a_sec == m_sec);
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, half a cycle after the edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R1 R2 R3 R5 time", 64'(time_o), 64'(exp_time()));
            chk("R4 R6 date", 64'(date_o), 64'(exp_date()));
            chk("R7 R10 alarm", 64'(alarm_irq), 64'(m_alarm));
            chk("R8 periodic", 64'(tick_irq), 64'(m_per));
            if (alarm_irq) alm_cnt++;
            if (tick_irq) per_cnt++;
        end
    end

    // reference tick generator
    initial begin
        forever begin
            @(posedge clk); #1;
            ref_tick = (ref_mode == 0) ? 1'b1 : ((cycles % 3) == 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == WDOG) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk); #1;
    endtask

    task automatic day_roll(input logic [31:0] d, input logic [31:0] exp_d, input string tag);
        wr(2'd1, d);
        wr(2'd0, 32'h0023_5959);
        run(N_MS * 1000 + 10);
        chk(tag, 64'(date_o), 64'(exp_d));
        chk("R3 hour wrap", 64'(time_o[35:12]), 64'h000000);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        chk("R9 reset time", 64'(time_o), 64'h0);
        chk("R9 reset date", 64'(date_o), 64'h2000_0101);
        chk("R9 reset irqs", 64'({alarm_irq, tick_irq}), 64'h0);

        // R1: free running
        run(5000);
        chk("R1 one second elapsed", 64'(time_o[35:12]), 64'h000001);

        // R5 and R6: loads take effect on the next edge
        wr(2'd1, 32'h1999_0712);
        chk("R6 date load", 64'(date_o), 64'h1999_0712);
        wr(2'd0, 32'h0000_0059);
        chk("R5 time load clears ms", 64'(time_o), {24'h000059, 12'h000});
        run(N_MS * 1000 + 10);
        chk("R2 second and minute carry", 64'(time_o[35:12]), 64'h000100);

        // R4 calendar rollovers
        day_roll(32'h2024_0228, 32'h2024_0229, "R4 leap February");
        day_roll(32'h2024_0229, 32'h2024_0301, "R4 leap end");
        day_roll(32'h2100_0228, 32'h2100_0301, "R4 century non-leap");
        day_roll(32'h2000_0228, 32'h2000_0229, "R4 quad century leap");
        day_roll(32'h2023_0430, 32'h2023_0501, "R4 thirty day month");
        day_roll(32'h9999_1231, 32'h0000_0101, "R4 year wrap");

        // R7 alarm match
        wr(2'd3, 32'h0000_0020);
        wr(2'd2, 32'h1512_0005);
        wr(2'd1, 32'h2023_0615);
        wr(2'd0, 32'h0012_0004);
        alm_cnt = 0;
        run(N_MS * 1000 + 10);
        chk("R7 alarm fires once", 64'(alm_cnt), 64'd1);

        // R7 day mismatch
        wr(2'd2, 32'h1612_0005);
        wr(2'd0, 32'h0012_0004);
        alm_cnt = 0;
        run(N_MS * 1000 + 10);
        chk("R7 alarm day mismatch", 64'(alm_cnt), 64'd0);

        // R10 alarm disabled
        wr(2'd2, 32'h1512_0005);
        wr(2'd3, 32'h0000_0000);
        wr(2'd0, 32'h0012_0004);
        alm_cnt = 0;
        run(N_MS * 1000 + 10);
        chk("R10 alarm ignored while disabled", 64'(alm_cnt), 64'd0);
        chk("R10 time still advanced", 64'(time_o[35:12]), 64'h120005);

        // R8 periodic rates
        per_cnt = 0; m_per_cnt = 0;
        wr(2'd3, 32'h0000_0019);
        run(800);
        chk("R8 512 Hz pulse count", 64'(per_cnt), 64'(m_per_cnt));
        chk("R8 512 Hz pulses present", 64'(per_cnt >= 98), 64'd1);
        per_cnt = 0; m_per_cnt = 0;
        wr(2'd3, 32'h0000_001F);
        run(800);
        chk("R8 selector above 9 clamps", 64'(per_cnt >= 98 && per_cnt <= 102), 64'd1);
        per_cnt = 0; m_per_cnt = 0;
        wr(2'd3, 32'h0000_0010);
        run(9000);
        chk("R8 1 Hz pulse count", 64'(per_cnt >= 2 && per_cnt <= 3), 64'd1);
        per_cnt = 0;
        wr(2'd3, 32'h0000_0009);
        run(2000);
        chk("R8 disabled no pulse", 64'(per_cnt), 64'd0);

        // R1 and R5 with sparse reference ticks
        ref_mode = 1;
        run(3000);
        wr(2'd0, 32'h0008_3030);
        chk("R5 load under sparse ticks", 64'(time_o), {24'h083030, 12'h000});
        run(2000);
        ref_mode = 0;
        run(20);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule